// File: doc/BRIEF.md
# Saturating uniform requantizer

This block places a wide signed digital sample on a uniform grid of 2^B levels that spans a programmable window `[lim_lo, lim_hi]`. It behaves like an ideal analog-to-digital converter working in the digital domain. It returns the level index and the reconstructed value of that level. It also raises a separate flag for each side when the sample falls outside the window. The width of the window must be a power of two. That makes the step size a plain power of two, so the block divides by shifting and needs no divider.

Each cell of the grid is open at its lower edge and closed at its upper edge. The reconstructed value is the midpoint of the cell. The window limits are sampled together with each sample, so they can change from one sample to the next. The result is registered, and it appears one clock after the valid strobe.

Top module: `sat_requantizer`

## Requirements
- R1: A result is registered on every clock where `in_valid` is high. `out_valid` is high exactly on the clock after a clock where `in_valid` was high.
- R2: On a clock where `in_valid` is low, `out_code`, `out_level`, `out_sat_hi` and `out_sat_lo` keep their values.
- R3: A sample at or above `lim_hi` gives `out_code` = 2^B-1 and `out_level` = `lim_hi` - step/2. It also sets `out_sat_hi` = 1 and `out_sat_lo` = 0.
- R4: A sample at or below `lim_lo` gives `out_code` = 0 and `out_level` = `lim_lo` + step/2. It also sets `out_sat_lo` = 1 and `out_sat_hi` = 0.
- R5: A sample strictly inside the window gives code c when it lies in the cell (`lim_lo` + step·c, `lim_lo` + step·(c+1)], with both flags 0. The lower edge of the cell is open and the upper edge is closed.
- R6: The reconstructed value is `lim_lo` + step·c + step/2 for the reported code c.
- R7: For a sample inside the window, the absolute difference between `out_level` and the sample never exceeds step/2.
- R8: With fixed limits, a larger sample never gives a smaller `out_code`.
- R9: The step is (`lim_hi` - `lim_lo`) / 2^B. This holds for any window whose span is a power of two of at least 2^(B+1), and the limits may change with every sample.
- R10: While `rst_n` is low, `out_valid`, `out_code`, `out_level` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | IN_W | Signed input sample |
| lim_lo | input | IN_W | Signed lower window limit |
| lim_hi | input | IN_W | Signed upper window limit |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_code | output | B | Level index |
| out_level | output | IN_W | Signed reconstructed level value |
| out_sat_hi | output | 1 | Sample was at or above `lim_hi` |
| out_sat_lo | output | 1 | Sample was at or below `lim_lo` |

## Verification
The hardest cases to reach are samples that sit exactly on a cell edge, or exactly on either limit. Random samples rarely land there, and those are the places where the open and closed edges and the saturation boundaries differ by a single code. The stimulus covers them in two ways. A unit-step ramp runs from below `lim_lo` to above `lim_hi`, so it crosses every edge of a fixed window. Random windows of varying power-of-two spans then get samples that are often placed within a few counts of a limit.

// File: rtl/sat_requantizer_pkg.sv
package sat_requantizer_pkg;

  typedef enum logic [1:0] {
    ZONE_BELOW = 2'd0,
    ZONE_INSIDE = 2'd1,
    ZONE_ABOVE = 2'd2
  } rq_zone_e;

endpackage

// File: rtl/rq_step_finder.sv
module rq_step_finder #(
  parameter int EW = 13,
  parameter int B  = 4,
  localparam int SW = $clog2(EW)
) (
  input  logic [EW-1:0] span,
  output logic [SW-1:0] step_sh
);

  logic [SW-1:0] msb_idx;

  always_comb begin
    msb_idx = '0;
    for (int i = 0; i < EW; i++) begin
      if (span[i]) msb_idx = SW'(i);
    end
  end

  always_comb begin
    if (msb_idx >= SW'(B)) step_sh = msb_idx - SW'(B);
    else step_sh = '0;
  end

endmodule

// File: rtl/rq_cell_map.sv
module rq_cell_map
  import sat_requantizer_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int B    = 4,
  localparam int EW = IN_W + 1,
  localparam int SW = $clog2(EW)
) (
  input  logic signed [IN_W-1:0] x,
  input  logic signed [IN_W-1:0] lo,
  input  logic signed [IN_W-1:0] hi,
  input  logic [SW-1:0]          step_sh,
  output logic [B-1:0]           code,
  output logic signed [IN_W-1:0] level,
  output logic                   sat_hi,
  output logic                   sat_lo
);

  logic signed [EW-1:0] x_e, lo_e, hi_e, offs_m1, step, half, level_e;
  logic [B-1:0]         cell_idx;
  rq_zone_e             zone;

  assign x_e  = EW'(x);
  assign lo_e = EW'(lo);
  assign hi_e = EW'(hi);

  always_comb begin
    if (x_e >= hi_e) zone = ZONE_ABOVE;
    else if (x_e <= lo_e) zone = ZONE_BELOW;
    else zone = ZONE_INSIDE;
  end

  // ceil((x - lo) / step) - 1 computed as (x - lo - 1) >> log2(step)
  assign offs_m1  = x_e - lo_e - EW'(1);
  assign cell_idx = B'(offs_m1 >>> step_sh);

  always_comb begin
    case (zone)
      ZONE_ABOVE: code = '1;
      ZONE_BELOW: code = '0;
      default:    code = cell_idx;
    endcase
  end

  assign step    = EW'(1) <<< step_sh;
  assign half    = step >>> 1;
  assign level_e = lo_e + (EW'(code) <<< step_sh) + half;
  assign level   = IN_W'(level_e);
  assign sat_hi  = (zone == ZONE_ABOVE);
  assign sat_lo  = (zone == ZONE_BELOW);

endmodule

// File: rtl/sat_requantizer.sv
module sat_requantizer #(
  parameter int IN_W = 12,
  parameter int B    = 4,
  localparam int EW = IN_W + 1,
  localparam int SW = $clog2(EW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  input  logic signed [IN_W-1:0] lim_lo,
  input  logic signed [IN_W-1:0] lim_hi,
  output logic                   out_valid,
  output logic [B-1:0]           out_code,
  output logic signed [IN_W-1:0] out_level,
  output logic                   out_sat_hi,
  output logic                   out_sat_lo
);

  logic [EW-1:0]          span;
  logic [SW-1:0]          step_sh;
  logic [B-1:0]           code_c, code_q, code_d;
  logic signed [IN_W-1:0] level_c, level_q, level_d;
  logic                   sat_hi_c, sat_hi_q, sat_hi_d;
  logic                   sat_lo_c, sat_lo_q, sat_lo_d;
  logic                   vld_q;

  assign span = EW'(EW'(lim_hi) - EW'(lim_lo));

  rq_step_finder #(.EW(EW), .B(B)) u_step (
    .span    (span),
    .step_sh (step_sh)
  );

  rq_cell_map #(.IN_W(IN_W), .B(B)) u_map (
    .x       (in_sample),
    .lo      (lim_lo),
    .hi      (lim_hi),
    .step_sh (step_sh),
    .code    (code_c),
    .level   (level_c),
    .sat_hi  (sat_hi_c),
    .sat_lo  (sat_lo_c)
  );

  always_comb begin
    code_d   = code_q;
    level_d  = level_q;
    sat_hi_d = sat_hi_q;
    sat_lo_d = sat_lo_q;
    if (in_valid) begin
      code_d   = code_c;
      level_d  = level_c;
      sat_hi_d = sat_hi_c;
      sat_lo_d = sat_lo_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      code_q   <= '0;
      level_q  <= '0;
      sat_hi_q <= 1'b0;
      sat_lo_q <= 1'b0;
    end else begin
      vld_q    <= in_valid;
      code_q   <= code_d;
      level_q  <= level_d;
      sat_hi_q <= sat_hi_d;
      sat_lo_q <= sat_lo_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_code   = code_q;
  assign out_level  = level_q;
  assign out_sat_hi = sat_hi_q;
  assign out_sat_lo = sat_lo_q;

endmodule

// File: rtl/sat_requantizer_chk.sv
module sat_requantizer_chk #(
  parameter int IN_W = 12,
  parameter int B    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic signed [IN_W-1:0] in_sample,
  input logic signed [IN_W-1:0] lim_lo,
  input logic signed [IN_W-1:0] lim_hi,
  input logic                   out_valid,
  input logic [B-1:0]           out_code,
  input logic signed [IN_W-1:0] out_level,
  input logic                   out_sat_hi,
  input logic                   out_sat_lo
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_code) && $stable(out_level) && $stable(out_sat_hi) && $stable(out_sat_lo)));
  a_r3_sat_hi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sample >= lim_hi)) |=> out_sat_hi);
  a_r3_top_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat_hi |-> (out_code == {B{1'b1}}));
  a_r4_sat_lo_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sample <= lim_lo) && (in_sample < lim_hi)) |=> out_sat_lo);
  a_r4_bottom_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat_lo |-> (out_code == '0));
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sat_hi && out_sat_lo));
  a_r5_inside_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sample > lim_lo) && (in_sample < lim_hi)) |=> (!out_sat_hi && !out_sat_lo));

endmodule

bind sat_requantizer sat_requantizer_chk #(.IN_W(IN_W), .B(B)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .lim_lo     (lim_lo),
  .lim_hi     (lim_hi),
  .out_valid  (out_valid),
  .out_code   (out_code),
  .out_level  (out_level),
  .out_sat_hi (out_sat_hi),
  .out_sat_lo (out_sat_lo)
);

// File: tb/tb_sat_requantizer.sv
module tb_sat_requantizer;
  localparam int CLK_P = 10;
  localparam int IN_W  = 12;
  localparam int B     = 4;
  localparam int TOPC  = (1 << B) - 1;

  logic clk, rst_n, in_valid;
  logic signed [IN_W-1:0] in_sample, lim_lo, lim_hi;
  logic out_valid, out_sat_hi, out_sat_lo;
  logic [B-1:0] out_code;
  logic signed [IN_W-1:0] out_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sat_requantizer #(.IN_W(IN_W), .B(B)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .out_valid(out_valid), .out_code(out_code),
    .out_level(out_level), .out_sat_hi(out_sat_hi), .out_sat_lo(out_sat_lo)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int x, input int lo, input int hi);
    int d, c;
    d = (hi - lo) >> B;
    if (x >= hi) return TOPC;
    if (x <= lo) return 0;
    c = 0;
    while (lo + d * (c + 1) < x) c++;
    return c;
  endfunction

  function automatic int exp_level(input int c, input int lo, input int hi);
    int d;
    d = (hi - lo) >> B;
    return lo + d * c + d / 2;
  endfunction

  int last_code;
  int last_level;

  // drive at a falling edge, sample at the next falling edge
  task automatic apply(input int x, input int lo, input int hi, input string tag);
    int ec, el, d;
    bit ehi, elo;
    in_valid  = 1'b1;
    in_sample = IN_W'(x);
    lim_lo    = IN_W'(lo);
    lim_hi    = IN_W'(hi);
    @(negedge clk);
    ec  = exp_code(x, lo, hi);
    el  = exp_level(ec, lo, hi);
    ehi = (x >= hi);
    elo = (x <= lo) && !ehi;
    d   = (hi - lo) >> B;
    chk(out_valid === 1'b1, {"R1 valid ", tag}, int'(out_valid), 1);
    if (ehi) chk(int'(out_code) == ec && out_sat_hi && !out_sat_lo,
                 {"R3 sat high code/flags ", tag}, int'(out_code), ec);
    else if (elo) chk(int'(out_code) == ec && out_sat_lo && !out_sat_hi,
                      {"R4 sat low code/flags ", tag}, int'(out_code), ec);
    else begin
      chk(int'(out_code) == ec && !out_sat_hi && !out_sat_lo,
          {"R5 cell code ", tag}, int'(out_code), ec);
      chk((int'(out_level) - x <= d / 2) && (x - int'(out_level) <= d / 2),
          {"R7 error bound ", tag}, int'(out_level), x);
    end
    chk(int'(out_level) == el, {"R6 R9 level ", tag}, int'(out_level), el);
    last_code  = int'(out_code);
    last_level = int'(out_level);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int prev;
    void'($urandom(32'd20140918));
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; lim_lo = '0; lim_hi = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && out_code == 0 && out_level == 0 && !out_sat_hi && !out_sat_lo,
        "R10 reset state", int'(out_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed edge cases, window [-200, 56), step 16
    apply(56, -200, 56, "x=hi");
    apply(55, -200, 56, "x=hi-1");
    chk(last_code == TOPC, "R5 top cell just below hi", last_code, TOPC);
    apply(-200, -200, 56, "x=lo");
    apply(-199, -200, 56, "x=lo+1");
    chk(last_code == 0, "R5 lower open edge", last_code, 0);
    apply(-184, -200, 56, "closed upper edge");
    chk(last_code == 0, "R5 closed upper edge", last_code, 0);
    apply(-183, -200, 56, "next cell");
    chk(last_code == 1, "R5 next cell starts", last_code, 1);

    // idle hold: change inputs with valid low
    in_valid = 1'b0; in_sample = 12'sd1000; lim_lo = -12'sd1000; lim_hi = 12'sd24;
    @(negedge clk);
    chk(!out_valid, "R1 valid drops", int'(out_valid), 0);
    chk(int'(out_code) == last_code && int'(out_level) == last_level && !out_sat_hi,
        "R2 hold when idle", int'(out_code), last_code);

    // ramp across and beyond both limits
    prev = -1;
    for (int x = -260; x <= 120; x++) begin
      apply(x, -200, 56, "ramp");
      chk(last_code >= prev, "R8 monotonic ramp", last_code, prev);
      prev = last_code;
    end

    // random windows with power-of-two spans
    for (int n = 0; n < 1500; n++) begin
      int k, span, lo, x;
      k    = B + 1 + int'($urandom % 7);
      span = 1 << k;
      lo   = -2048 + int'($urandom % (4096 - span));
      case ($urandom % 4)
        0: x = lo + int'($urandom % 5) - 2;
        1: x = lo + span + int'($urandom % 5) - 2;
        default: x = -2048 + int'($urandom % 4096);
      endcase
      if (x > 2047) x = 2047;
      if (x < -2048) x = -2048;
      apply(x, lo, lo + span, "random");
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule